// File: doc/BRIEF.md
# Byte-Wide EEPROM Write-Cycle Status Model

This block plays the memory side of a byte-wide parallel EEPROM with a self-timed internal write. A host drives active-low chip enable, output enable and write enable, an address and a data byte, and it reads bytes back through a data output with its own drive enable. A write-enable rising edge captures one byte into a pending buffer and opens a load window. If no further byte arrives before the window times out, an internal write cycle starts. At its end every pending byte is committed together into a small internal array.

From the first captured byte until the commit, a read returns a status byte instead of stored data. This lets the host poll for completion in either of two ways: it can watch the inverted top bit, or it can watch a bit that alternates on every read. One more status bit shows whether the load window is still open. A separate digital flag stands in for the high-voltage erase condition on output enable. With that flag set, a long enough write-enable low pulse fills the whole array with FFh. A recovery period follows, during which writes are refused.

All controls are sampled on the clock. Edges are found by comparing each sample with the one taken in the previous cycle. Every duration is a parameter counted in clock cycles.

Top module: `eep_status_emu`

## Requirements
- R1: After reset every byte of the array holds 00h, no write is pending, and reads return the stored byte of the addressed location.
- R2: `dq_oe` is high exactly when `ce_n` is low, `oe_n` is low and `hv_erase` is low.
- R3: A byte is captured when `we_n` is sampled high one cycle after being sampled low, with `ce_n` low, `oe_n` high and `hv_erase` low. Address and data are taken from that same sample.
- R4: The internal write starts LOAD_TMO cycles after the most recent capture. A capture in any cycle of the window, including the cycle in which the window would expire, restarts the window.
- R5: The internal write lasts WRITE_CYC cycles. Every byte captured in the window is then committed at once, untouched addresses keep their contents, and later reads return the stored data.
- R6: While a write is pending or running, a read returns a status byte. Bit 7 of that byte is the complement of bit 7 of the last captured byte, and bits 4..0 are 0.
- R7: Status bit 6 reads 0 on the first read of a programming cycle and flips after every read. One read is one low period of `oe_n`, ending while `ce_n` is low.
- R8: Status bit 5 is 1 while the load window is open and 0 during the internal write.
- R9: A capture attempted during the internal write is ignored. It neither changes the array nor starts a new cycle.
- R10: With `hv_erase` high and `ce_n` low, a `we_n` low pulse of at least ERASE_MIN sampled cycles sets every byte to FFh on its rising edge. A shorter pulse leaves the array unchanged.
- R11: For RECOV_CYC cycles after an erase, captures are ignored. After that period, captures work again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hv_erase | input | 1 | Stands in for the erase voltage on output enable |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data from the host |
| dq_o | output | 8 | Data or status byte to the host |
| dq_oe | output | 1 | Drive enable for `dq_o` |

## Verification
The load-window timer can expire in the same cycle that a new byte is captured, and the capture must win. The bench provokes this by placing a write-enable rising edge exactly on the expiring cycle of the window. It then judges the result by reading status bit 5, which must still be 1 with bit 6 back at 0. After the cycle completes, both the early byte and the late byte must be present in the array. A rising edge one cycle later falls inside the internal write and must be ignored, and that case is checked separately.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RECOV = 2'd3
  } eep_state_t;

  // Status byte shown while a programming cycle is in progress.
  function automatic logic [7:0] status_byte(input logic last_b7,
                                             input logic tog,
                                             input logic window_open);
    return {~last_b7, tog, window_open, 5'b00000};
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eep_edge.sv
module eep_edge #(
  parameter int          N       = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int LOAD_TMO  = 12,
  parameter int WRITE_CYC = 24,
  parameter int ERASE_MIN = 16,
  parameter int RECOV_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       hv_erase,
  input  logic       we_rise,
  input  logic       oe_rise,
  input  logic       latch_req,
  output eep_state_t st_o,
  output logic       latch_acc,
  output logic       commit,
  output logic       erase_fire,
  output logic       tog_o
);
  localparam int TMAX = max3(LOAD_TMO, WRITE_CYC, RECOV_CYC);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int EW   = $clog2(ERASE_MIN + 1);

  eep_state_t    st;
  logic [TW-1:0] tmr;
  logic [EW-1:0] ecnt;
  logic          tog;
  logic          busy, read_end, erase_hold, load_done, recov_done;

  assign busy       = (st == ST_LOAD) || (st == ST_WRITE);
  assign read_end   = oe_rise && !ce_n;
  assign erase_hold = (st == ST_IDLE) && !ce_n && hv_erase && !we_n;
  assign load_done  = (tmr == TW'(LOAD_TMO - 1));
  assign recov_done = (tmr == TW'(RECOV_CYC - 1));
  assign commit     = (st == ST_WRITE) && (tmr == TW'(WRITE_CYC - 1));
  assign erase_fire = (st == ST_IDLE) && we_rise && !ce_n && hv_erase &&
                      (ecnt == EW'(ERASE_MIN));
  assign latch_acc  = latch_req && ((st == ST_IDLE) || (st == ST_LOAD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      tmr  <= '0;
      ecnt <= '0;
      tog  <= 1'b0;
    end else begin
      if (erase_hold) ecnt <= (ecnt == EW'(ERASE_MIN)) ? ecnt : ecnt + 1'b1;
      else            ecnt <= '0;
      if (busy && read_end) tog <= ~tog;
      unique case (st)
        ST_IDLE: begin
          if (latch_req) begin
            st  <= ST_LOAD;
            tmr <= '0;
            tog <= 1'b0;
          end else if (erase_fire) begin
            st  <= ST_RECOV;
            tmr <= '0;
          end
        end
        ST_LOAD: begin
          if (latch_req) tmr <= '0;
          else if (load_done) begin
            st  <= ST_WRITE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_WRITE: begin
          if (commit) begin
            st  <= ST_IDLE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_RECOV: begin
          if (recov_done) begin
            st  <= ST_IDLE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign st_o  = st;
  assign tog_o = tog;

  // R4
  enter_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_WRITE) |-> $past(st) == ST_LOAD);

  // R4
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD && latch_req) |=> (st == ST_LOAD && tmr == '0));

  // R7
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && read_end) |=> tog != $past(tog));

  // R11
  recov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOV) |=> (st == ST_RECOV || st == ST_IDLE));
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          latch_acc,
  input  logic                          commit,
  input  logic                          erase_fire,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    din,
  output logic [7:0]                    rd_byte,
  output logic                          last_b7,
  output logic [(1<<ADDR_W)-1:0]        pend_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][7:0] mem_q;
  logic [DEPTH-1:0][7:0] pbuf_q;
  logic [DEPTH-1:0]      pvld_q;
  logic [DEPTH-1:0]      hit;
  logic                  b7_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit[i] = latch_acc && (addr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '0;
      pbuf_q <= '0;
      pvld_q <= '0;
      b7_q   <= 1'b0;
    end else begin
      if (latch_acc) b7_q <= din[7];
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_fire) mem_q[i] <= 8'hFF;
        else if (commit && pvld_q[i]) mem_q[i] <= pbuf_q[i];
        if (hit[i]) pbuf_q[i] <= din;
        if (commit) pvld_q[i] <= 1'b0;
        else if (hit[i]) pvld_q[i] <= 1'b1;
      end
    end
  end

  assign rd_byte = mem_q[addr];
  assign last_b7 = b7_q;
  assign pend_o  = pvld_q;

  // R10
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |=> (&mem_q));

  // R5
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (pvld_q == '0));
endmodule

// File: rtl/eep_status_emu.sv
module eep_status_emu
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LOAD_TMO  = 12,
  parameter int WRITE_CYC = 24,
  parameter int ERASE_MIN = 16,
  parameter int RECOV_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hv_erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]       rise;
  logic             we_rise, oe_rise, latch_req;
  eep_state_t       st;
  logic             latch_acc, commit, erase_fire, tog;
  logic [7:0]       rd_byte;
  logic             last_b7, busy;
  logic [DEPTH-1:0] pend;

  eep_edge #(.N(2), .RST_VAL(2'b11)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({oe_n, we_n}),
    .rise_o (rise)
  );
  assign we_rise   = rise[0];
  assign oe_rise   = rise[1];
  assign latch_req = we_rise && !ce_n && oe_n && !hv_erase;

  eep_seq #(
    .LOAD_TMO (LOAD_TMO),
    .WRITE_CYC(WRITE_CYC),
    .ERASE_MIN(ERASE_MIN),
    .RECOV_CYC(RECOV_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .hv_erase  (hv_erase),
    .we_rise   (we_rise),
    .oe_rise   (oe_rise),
    .latch_req (latch_req),
    .st_o      (st),
    .latch_acc (latch_acc),
    .commit    (commit),
    .erase_fire(erase_fire),
    .tog_o     (tog)
  );

  eep_store #(.ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_acc (latch_acc),
    .commit    (commit),
    .erase_fire(erase_fire),
    .addr      (addr),
    .din       (dq_i),
    .rd_byte   (rd_byte),
    .last_b7   (last_b7),
    .pend_o    (pend)
  );

  assign busy  = (st == ST_LOAD) || (st == ST_WRITE);
  assign dq_oe = !ce_n && !oe_n && !hv_erase;
  assign dq_o  = busy ? status_byte(last_b7, tog, st == ST_LOAD) : rd_byte;

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRITE && latch_req && !commit) |=> $stable(pend));

  // R5
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (st == ST_IDLE && pend == '0));

  // R3
  capture_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_req && st == ST_IDLE) |=> (pend != '0));
endmodule

// File: tb/eep_status_emu_tb.sv
`timescale 1ns/1ps
module eep_status_emu_tb;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int LT = 12;
  localparam int WC = 24;
  localparam int EM = 16;
  localparam int RC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_i = '0;
  logic [7:0] dq_o;
  logic dq_oe;

  int total = 0, bad = 0, k = 0;
  logic [7:0] ref_mem [DEPTH];
  bit done = 0;

  always #10 clk = ~clk;

  eep_status_emu #(.ADDR_W(AW), .LOAD_TMO(LT), .WRITE_CYC(WC),
                   .ERASE_MIN(EM), .RECOV_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hv_erase(hv), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe));

  function automatic logic [7:0] exp_status(logic [7:0] last, bit tog, bit win);
    logic [7:0] s;
    s = 8'h00;
    s[7] = !last[7];
    s[6] = tog;
    s[5] = win;
    return s;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); k++;
  endtask

  task automatic wait_to(int t);
    while (k < t) tick();
  endtask

  task automatic latch(logic [AW-1:0] a, logic [7:0] d);
    addr = a; dq_i = d; we_n = 1'b0;
    tick();
    we_n = 1'b1;
    tick();
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    addr = a; oe_n = 1'b0;
    #2 v = dq_o;
    tick();
    oe_n = 1'b1;
    tick();
  endtask

  task automatic check_all(string req);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), v);
      chk(req, v, ref_mem[i]);
    end
  endtask

  task automatic erase_pulse(int n);
    hv = 1'b1; we_n = 1'b0;
    repeat (n) tick();
    we_n = 1'b1;
    tick();
    hv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d, e;
    logic [AW-1:0] a, b;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; ce_n = 1'b0;
    tick();

    // R1: reset contents
    check_all("R1");

    // R2: output enable decode
    oe_n = 1'b1; #1 chk("R2", {7'b0, dq_oe}, 8'h00);
    oe_n = 1'b0; #1 chk("R2", {7'b0, dq_oe}, 8'h01);
    ce_n = 1'b1; #1 chk("R2", {7'b0, dq_oe}, 8'h00);
    ce_n = 1'b0; hv = 1'b1; #1 chk("R2", {7'b0, dq_oe}, 8'h00);
    hv = 1'b0; oe_n = 1'b1;
    tick();

    // R3 R6 R7 R8 R4 R5: single byte, status timeline
    a = AW'($urandom_range(0, DEPTH-1));
    d = 8'($urandom) | 8'h80;
    latch(a, d); k = 0;
    rd(a, v); chk("R6 R7 R8", v, exp_status(d, 0, 1));
    rd(a, v); chk("R7", v, exp_status(d, 1, 1));
    rd(AW'(a + 1), v); chk("R7", v, exp_status(d, 0, 1));
    wait_to(LT - 1);
    rd(a, v); chk("R4 R8", v, exp_status(d, 1, 1));
    rd(a, v); chk("R4 R8", v, exp_status(d, 0, 0));
    wait_to(LT + WC - 1);
    rd(a, v); chk("R5", v, exp_status(d, 1, 0));
    rd(a, v); chk("R5 R3", v, d);
    ref_mem[a] = d;

    // R6 with a clear top bit
    e = 8'($urandom) & 8'h7F;
    latch(AW'(a + 3), e);
    rd(a, v); chk("R6", v, exp_status(e, 0, 1));
    ref_mem[AW'(a + 3)] = e;
    repeat (60) tick();
    check_all("R5");

    // R5: several bytes in one window
    a = AW'($urandom_range(0, DEPTH-1));
    for (int j = 0; j < 3; j++) begin
      d = 8'($urandom);
      latch(AW'(a + 5 * j), d);
      ref_mem[AW'(a + 5 * j)] = d;
    end
    repeat (60) tick();
    check_all("R5");

    // R9: capture during internal write ignored
    a = AW'($urandom_range(0, DEPTH-1));
    b = AW'(a + 7);
    d = 8'($urandom);
    e = ~ref_mem[b];
    latch(a, d); k = 0; ref_mem[a] = d;
    wait_to(LT + 2);
    latch(b, e);
    repeat (60) tick();
    rd(b, v); chk("R9", v, ref_mem[b]);
    rd(a, v); chk("R9", v, d);

    // R4: capture in the cycle the window expires restarts it
    a = AW'($urandom_range(0, DEPTH-1));
    b = AW'(a + 2);
    d = 8'($urandom); e = 8'($urandom);
    latch(a, d); k = 0;
    wait_to(LT - 2);
    latch(b, e);
    rd(a, v); chk("R4 R8", v, exp_status(e, 0, 1));
    ref_mem[a] = d; ref_mem[b] = e;
    repeat (60) tick();
    check_all("R4");

    // R3 R5: random rounds
    for (int r = 0; r < 5; r++) begin
      int n;
      n = $urandom_range(1, 4);
      for (int j = 0; j < n; j++) begin
        a = AW'($urandom_range(0, DEPTH-1));
        d = 8'($urandom);
        latch(a, d);
        ref_mem[a] = d;
      end
      repeat (60) tick();
      check_all("R3 R5");
    end

    // R10: short erase pulse has no effect
    ref_mem[0] = 8'h3C; latch(0, 8'h3C);
    repeat (60) tick();
    erase_pulse(EM - 1);
    repeat (4) tick();
    check_all("R10");

    // R10 R11: full erase, then capture in recovery is ignored
    erase_pulse(EM); k = 0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    latch(3, 8'h00);
    repeat (60) tick();
    check_all("R10 R11");

    // R11: capture works after recovery
    latch(3, 8'h5A); ref_mem[3] = 8'h5A;
    repeat (60) tick();
    rd(3, v); chk("R11", v, 8'h5A);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule